// File: doc/BRIEF.md
# Shadow L1-Tag Coherence Directory

This block is the coherence directory for one home bank of a shared last-level cache in a multi-core chip. The bank is exclusive of the private L1 caches. It does not track its own lines. For each core it holds a copy of the tags of the L1 lines whose home is this bank, and searches every copy in parallel in the manner of a content-addressable memory. A line dropped by the L2 bank can never be in any L1, so L2 evictions leave the directory alone. Home banks are interleaved by line address: line k belongs to bank k mod 2^BANK_W. The low BANK_W bits of a line address therefore carry no information inside one bank, and the stored tag is the remaining upper bits.

L1 controllers post fill and eviction notices. Requesters post read and write lookups. All of these arrive on one valid/ready request channel, at most one per cycle. A transfer happens on a rising edge where `req_valid` and `req_ready` are both high. The requester must hold the request fields stable while `req_valid` is high and `req_ready` is low. A lookup answers with a sharer vector one cycle after acceptance. A write lookup also starts a train of invalidation commands, one per cycle. Each command removes that core's copied tag. `req_ready` stays low while the train runs. The invalidation output has no back-pressure: the interconnect takes one command per cycle.

Top module: `shadow_tag_dir`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` is 0, `inv_valid` is 0 and `overflow` is 0.
- R2: The tag is `req_line[LINE_W-1:BANK_W]`. The low BANK_W bank-select bits are ignored, so two lines that differ only in those bits are the same directory entry.
- R3: Opcodes are `req_op` 0 = L1 fill, 1 = L1 eviction, 2 = read lookup, 3 = write lookup, 4 = L2 eviction. A fill installs the tag in core `req_core`'s store. `rsp_valid` pulses for one cycle, the cycle after a read or write lookup is accepted, and never for the other opcodes.
- R4: A read lookup returns `rsp_sharers` with bit c set exactly when core c holds the tag.
- R5: A fill of a tag that the core already holds changes nothing. A single L1 eviction then removes the tag.
- R6: An L1 eviction removes the tag from that core only. Evicting a tag that is absent changes nothing.
- R7: A write lookup from core w returns the holders of the tag with bit w cleared. Core w keeps its own copy.
- R8: Each other holder gets one invalidation (`inv_valid`, `inv_core`, `inv_tag`) per cycle, in ascending core order. The first one appears in the same cycle as the response. The tag copy of each core is removed as its command is issued.
- R9: `req_ready` is low in exactly the cycles in which an invalidation is being issued. A request held during that time is accepted once the train ends.
- R10: An accepted L2 eviction produces no response and no invalidation, and leaves every tag copy unchanged.
- R11: A fill of a new tag into a core store that already has ENTRIES_PER_CORE valid tags is dropped. It sets `overflow`, which stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_op | input | 3 | Request opcode (see R3) |
| req_core | input | CORE_W | Core that sent the notice or lookup |
| req_line | input | LINE_W | Physical line address |
| rsp_valid | output | 1 | Lookup response valid |
| rsp_sharers | output | N_CORES | Sharer vector, bit per core |
| inv_valid | output | 1 | Invalidation command valid |
| inv_core | output | CORE_W | Core to invalidate |
| inv_tag | output | TAG_W | Tag to invalidate |
| overflow | output | 1 | Sticky: a fill found its core store full |

## Verification
The bench goes after write lookups with the writer among the holders, and with the writer not holding the line at all. A design that forgot the writer mask would invalidate the writer's own copy, and a later read would show that core missing. Trains with gaps in the holder set test the ascending order and the one-per-cycle rule. A sequencer that skipped or repeated a bit would send a wrong `inv_core`, or keep `req_ready` low for the wrong number of cycles. A request held across a train must wait for the train and then see the cleared holders. Fill, eviction and L2-eviction mixes compared against a set model catch duplicate fills taking a second slot, stray clears and L2 evictions that leak into the stores. A full store is hit with a repeated tag, which must not flag, and then with one new tag, which must.

// File: rtl/shadow_dir_pkg.sv
package shadow_dir_pkg;
  localparam logic [2:0] OP_FILL     = 3'd0;
  localparam logic [2:0] OP_L1_EVICT = 3'd1;
  localparam logic [2:0] OP_READ     = 3'd2;
  localparam logic [2:0] OP_WRITE    = 3'd3;
  localparam logic [2:0] OP_L2_EVICT = 3'd4;
endpackage

// File: rtl/tag_cam.sv
module tag_cam #(
  parameter int ENTRIES = 16,
  parameter int TAG_W   = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TAG_W-1:0] look_tag,
  output logic             look_hit,
  input  logic             fill_en,
  input  logic             clr_en,
  input  logic [TAG_W-1:0] clr_tag,
  output logic             fill_drop
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [TAG_W-1:0]   tag_q [ENTRIES];
  logic [ENTRIES-1:0] vld_q;
  logic [ENTRIES-1:0] hit_vec;
  logic [ENTRIES-1:0] clr_vec;
  logic               free_found;
  logic [IDX_W-1:0]   free_idx;
  logic               do_write;

  always_comb begin
    free_found = 1'b0;
    free_idx   = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      hit_vec[i] = vld_q[i] && (tag_q[i] == look_tag);
      clr_vec[i] = vld_q[i] && (tag_q[i] == clr_tag);
      if (!vld_q[i] && !free_found) begin
        free_found = 1'b1;
        free_idx   = IDX_W'(i);
      end
    end
  end

  assign look_hit  = |hit_vec;
  assign do_write  = fill_en && !look_hit && free_found;
  assign fill_drop = fill_en && !look_hit && !free_found;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
    end else begin
      if (clr_en)   vld_q <= vld_q & ~clr_vec;
      if (do_write) vld_q[free_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (do_write) tag_q[free_idx] <= look_tag;
  end
endmodule

// File: rtl/inv_sequencer.sv
module inv_sequencer #(
  parameter int N_CORES = 8,
  localparam int CORE_W = (N_CORES > 1) ? $clog2(N_CORES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [N_CORES-1:0] load_mask,
  output logic               busy,
  output logic [CORE_W-1:0]  cur_idx,
  output logic [N_CORES-1:0] cur_onehot
);
  logic [N_CORES-1:0] pending_q;

  assign busy       = |pending_q;
  assign cur_onehot = pending_q & (~pending_q + N_CORES'(1));

  always_comb begin
    cur_idx = '0;
    for (int i = N_CORES - 1; i >= 0; i--) begin
      if (pending_q[i]) cur_idx = CORE_W'(i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pending_q <= '0;
    else if (load) pending_q <= load_mask;
    else if (busy) pending_q <= pending_q & ~cur_onehot;
  end
endmodule

// File: rtl/shadow_tag_dir.sv
module shadow_tag_dir
  import shadow_dir_pkg::*;
#(
  parameter int N_CORES          = 8,
  parameter int ENTRIES_PER_CORE = 16,
  parameter int LINE_W           = 12,
  parameter int BANK_W           = 2,
  localparam int TAG_W           = LINE_W - BANK_W,
  localparam int CORE_W          = (N_CORES > 1) ? $clog2(N_CORES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [2:0]         req_op,
  input  logic [CORE_W-1:0]  req_core,
  input  logic [LINE_W-1:0]  req_line,
  output logic               rsp_valid,
  output logic [N_CORES-1:0] rsp_sharers,
  output logic               inv_valid,
  output logic [CORE_W-1:0]  inv_core,
  output logic [TAG_W-1:0]   inv_tag,
  output logic               overflow
);
  logic               accept;
  logic [TAG_W-1:0]   req_tag;
  logic [TAG_W-1:0]   wtag_q;
  logic [TAG_W-1:0]   clr_tag;
  logic [N_CORES-1:0] hit_v;
  logic [N_CORES-1:0] drop_v;
  logic [N_CORES-1:0] req_onehot;
  logic [N_CORES-1:0] others;
  logic               seq_busy;
  logic [N_CORES-1:0] seq_onehot;
  logic [CORE_W-1:0]  seq_idx;
  logic               is_lookup;
  logic               is_write;
  logic               rsp_valid_q;
  logic [N_CORES-1:0] rsp_sharers_q;
  logic               ovf_q;

  assign req_ready  = !seq_busy;
  assign accept     = req_valid && req_ready;
  assign req_tag    = req_line[LINE_W-1:BANK_W];
  assign req_onehot = N_CORES'(1) << req_core;
  assign is_write   = (req_op == OP_WRITE);
  assign is_lookup  = (req_op == OP_READ) || is_write;
  assign others     = hit_v & ~req_onehot;
  assign clr_tag    = seq_busy ? wtag_q : req_tag;

  for (genvar g = 0; g < N_CORES; g++) begin : g_core
    logic mine;
    logic fill_en;
    logic clr_en;
    assign mine    = accept && (req_core == CORE_W'(g));
    assign fill_en = mine && (req_op == OP_FILL);
    assign clr_en  = (mine && (req_op == OP_L1_EVICT)) ||
                     (seq_busy && seq_onehot[g]);
    tag_cam #(
      .ENTRIES (ENTRIES_PER_CORE),
      .TAG_W   (TAG_W)
    ) u_cam (
      .clk       (clk),
      .rst_n     (rst_n),
      .look_tag  (req_tag),
      .look_hit  (hit_v[g]),
      .fill_en   (fill_en),
      .clr_en    (clr_en),
      .clr_tag   (clr_tag),
      .fill_drop (drop_v[g])
    );
  end

  inv_sequencer #(.N_CORES(N_CORES)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (accept && is_write),
    .load_mask  (others),
    .busy       (seq_busy),
    .cur_idx    (seq_idx),
    .cur_onehot (seq_onehot)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q   <= 1'b0;
      rsp_sharers_q <= '0;
      wtag_q        <= '0;
      ovf_q         <= 1'b0;
    end else begin
      rsp_valid_q <= accept && is_lookup;
      if (accept && is_lookup) rsp_sharers_q <= is_write ? others : hit_v;
      if (accept && is_write)  wtag_q <= req_tag;
      if (|drop_v)             ovf_q <= 1'b1;
    end
  end

  assign rsp_valid   = rsp_valid_q;
  assign rsp_sharers = rsp_sharers_q;
  assign inv_valid   = seq_busy;
  assign inv_core    = seq_idx;
  assign inv_tag     = wtag_q;
  assign overflow    = ovf_q;
endmodule

// File: rtl/shadow_tag_dir_chk.sv
module shadow_tag_dir_chk
  import shadow_dir_pkg::*;
#(
  parameter int N_CORES = 8,
  parameter int CORE_W  = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_ready,
  input logic [2:0]         req_op,
  input logic [CORE_W-1:0]  req_core,
  input logic               rsp_valid,
  input logic [N_CORES-1:0] rsp_sharers,
  input logic               inv_valid,
  input logic [CORE_W-1:0]  inv_core,
  input logic               overflow
);
  // R1 reset state
  always_comb begin
    if (!rst_n) begin
      assert_reset_idle_R1: assert (req_ready && !rsp_valid && !inv_valid && !overflow)
        else $error("R1 outputs not idle in reset");
    end
  end

  // R3 response only after an accepted lookup
  assert_rsp_after_lookup_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid && req_ready && (req_op == OP_READ || req_op == OP_WRITE)));

  // R7 writer never listed in its own response
  assert_writer_masked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && $past(req_op) == OP_WRITE) |-> !rsp_sharers[$past(req_core)]);

  // R8 strictly ascending core order within a train
  assert_inv_ascending_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_valid && $past(inv_valid)) |-> (inv_core > $past(inv_core)));

  // R9 back-pressure while invalidations run
  assert_stall_during_inv_R9: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid |-> !req_ready);

  // R10 an L2 eviction yields no response
  assert_l2_evict_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_op == OP_L2_EVICT) |=> !rsp_valid);

  // R11 overflow is sticky
  assert_no_overflow_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(overflow) |-> overflow);
endmodule

bind shadow_tag_dir shadow_tag_dir_chk #(
  .N_CORES (N_CORES),
  .CORE_W  (CORE_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .req_op      (req_op),
  .req_core    (req_core),
  .rsp_valid   (rsp_valid),
  .rsp_sharers (rsp_sharers),
  .inv_valid   (inv_valid),
  .inv_core    (inv_core),
  .overflow    (overflow)
);

// File: tb/shadow_tag_dir_test.sv
`timescale 1ns/1ps
module shadow_tag_dir_test;
  localparam int N      = 8;
  localparam int ENT    = 16;
  localparam int LW     = 12;
  localparam int BW     = 2;
  localparam int TW     = LW - BW;
  localparam int CW     = 3;
  localparam int NTAGS  = 1 << TW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [2:0]    req_op = '0;
  logic [CW-1:0] req_core = '0;
  logic [LW-1:0] req_line = '0;
  logic          rsp_valid;
  logic [N-1:0]  rsp_sharers;
  logic          inv_valid;
  logic [CW-1:0] inv_core;
  logic [TW-1:0] inv_tag;
  logic          overflow;

  always #2 clk = ~clk;

  shadow_tag_dir #(.N_CORES(N), .ENTRIES_PER_CORE(ENT), .LINE_W(LW), .BANK_W(BW)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_core(req_core), .req_line(req_line),
    .rsp_valid(rsp_valid), .rsp_sharers(rsp_sharers), .inv_valid(inv_valid),
    .inv_core(inv_core), .inv_tag(inv_tag), .overflow(overflow));

  int  compared = 0;
  int  mismatched = 0;
  bit  done = 1'b0;
  bit  ref_has [N][NTAGS];
  int  ref_cnt [N];
  bit  ref_ovf;

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  function automatic logic [N-1:0] holders(input int t);
    logic [N-1:0] v = '0;
    for (int c = 0; c < N; c++) v[c] = ref_has[c][t];
    return v;
  endfunction

  task automatic model_reset();
    for (int c = 0; c < N; c++) begin
      ref_cnt[c] = 0;
      for (int t = 0; t < NTAGS; t++) ref_has[c][t] = 1'b0;
    end
    ref_ovf = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    req_valid = 1'b0;
    model_reset();
    repeat (2) @(negedge clk);
    chk(req_ready === 1'b1 && rsp_valid === 1'b0 && inv_valid === 1'b0 && overflow === 1'b0,
        "R1", "idle outputs in reset", {req_ready, rsp_valid, inv_valid, overflow}, 4'b1000);
    rst_n = 1'b1;
  endtask

  // Issue one request; ready is high on entry because trains are drained.
  task automatic issue(input logic [2:0] op, input int core, input int tag, input int bank,
                       input string rq);
    logic [N-1:0] exp;
    exp = '0;
    @(negedge clk);
    req_valid = 1'b1;
    req_op    = op;
    req_core  = CW'(core);
    req_line  = {TW'(tag), BW'(bank)};
    case (op)
      3'd0: if (!ref_has[core][tag]) begin
              if (ref_cnt[core] < ENT) begin ref_has[core][tag] = 1'b1; ref_cnt[core]++; end
              else ref_ovf = 1'b1;
            end
      3'd1: if (ref_has[core][tag]) begin ref_has[core][tag] = 1'b0; ref_cnt[core]--; end
      3'd2: exp = holders(tag);
      3'd3: begin exp = holders(tag); exp[core] = 1'b0; end
      default: ;
    endcase
    @(negedge clk);
    req_valid = 1'b0;
    if (op == 3'd2 || op == 3'd3) begin
      chk(rsp_valid === 1'b1, rq, "rsp_valid after lookup", rsp_valid, 1);
      chk(rsp_sharers === exp, rq, "sharer vector", rsp_sharers, exp);
    end else begin
      chk(rsp_valid === 1'b0, rq, "no response for notice", rsp_valid, 0);
    end
    if (op == 3'd3) begin
      for (int c = 0; c < N; c++) begin
        if (exp[c]) begin
          chk(inv_valid === 1'b1 && inv_core === CW'(c), "R8", "invalidation core",
              {inv_valid, inv_core}, {1'b1, CW'(c)});
          chk(inv_tag === TW'(tag), "R8", "invalidation tag", inv_tag, tag);
          chk(req_ready === 1'b0, "R9", "ready low during train", req_ready, 0);
          ref_has[c][tag] = 1'b0;
          ref_cnt[c]--;
          @(negedge clk);
        end
      end
    end
    chk(inv_valid === 1'b0, "R8", "train ended", inv_valid, 0);
    chk(req_ready === 1'b1, "R9", "ready after train", req_ready, 1);
    chk(overflow === ref_ovf, "R11", "overflow flag", overflow, ref_ovf);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    int r;
    void'($urandom(32'd20250));
    do_reset();

    // R3 R4 R2: fill, read through another bank-select value
    issue(3'd0, 2, 40, 0, "R3");
    issue(3'd2, 0, 40, 3, "R2");
    issue(3'd0, 5, 40, 1, "R3");
    issue(3'd2, 7, 40, 2, "R4");
    // R5 idempotent fill, one eviction removes
    issue(3'd0, 2, 40, 2, "R5");
    issue(3'd1, 2, 40, 1, "R5");
    issue(3'd2, 0, 40, 0, "R5");
    // R6 evict of absent tag
    issue(3'd1, 3, 40, 0, "R6");
    issue(3'd2, 1, 40, 0, "R6");
    // R7 writer holds line, others at 0,3,7
    issue(3'd0, 0, 41, 0, "R7");
    issue(3'd0, 3, 41, 0, "R7");
    issue(3'd0, 4, 41, 0, "R7");
    issue(3'd0, 7, 41, 0, "R7");
    issue(3'd3, 4, 41, 1, "R7");
    issue(3'd2, 6, 41, 0, "R7");
    // R7 writer not a holder
    issue(3'd3, 1, 40, 0, "R7");
    issue(3'd2, 1, 40, 0, "R7");
    // R10 L2 eviction leaves copies
    issue(3'd0, 6, 42, 0, "R10");
    issue(3'd4, 0, 42, 0, "R10");
    issue(3'd2, 0, 42, 0, "R10");

    // R9 request held across a train
    issue(3'd0, 1, 50, 0, "R9");
    issue(3'd0, 4, 50, 0, "R9");
    issue(3'd0, 6, 50, 0, "R9");
    @(negedge clk);
    req_valid = 1'b1; req_op = 3'd3; req_core = 3'd4; req_line = {TW'(50), BW'(0)};
    @(negedge clk);
    req_op = 3'd2; req_core = 3'd0;
    chk(rsp_sharers === 8'b0100_0010, "R7", "held write response", rsp_sharers, 8'b0100_0010);
    chk(inv_valid === 1'b1 && inv_core === 3'd1 && req_ready === 1'b0, "R9", "first stall cycle",
        {inv_valid, inv_core, req_ready}, {1'b1, 3'd1, 1'b0});
    @(negedge clk);
    chk(inv_valid === 1'b1 && inv_core === 3'd6 && req_ready === 1'b0, "R9", "second stall cycle",
        {inv_valid, inv_core, req_ready}, {1'b1, 3'd6, 1'b0});
    @(negedge clk);
    chk(req_ready === 1'b1 && inv_valid === 1'b0, "R9", "ready returns", req_ready, 1);
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_valid === 1'b1 && rsp_sharers === 8'b0001_0000, "R9", "held read result",
        rsp_sharers, 8'b0001_0000);
    ref_has[1][50] = 1'b0; ref_cnt[1]--;
    ref_has[6][50] = 1'b0; ref_cnt[6]--;

    // random mix, tag pool small enough to never fill a store
    for (int i = 0; i < 3000; i++) begin
      int t, c, b;
      logic [2:0] op;
      t = $urandom_range(0, 11);
      c = $urandom_range(0, N - 1);
      b = $urandom_range(0, 3);
      r = $urandom_range(0, 99);
      if (r < 35)      op = 3'd0;
      else if (r < 55) op = 3'd1;
      else if (r < 75) op = 3'd2;
      else if (r < 90) op = 3'd3;
      else             op = 3'd4;
      issue(op, c, t, b, "R4");
    end
    for (int t = 0; t < 12; t++) issue(3'd2, 0, t, 0, "R10");

    // R11 overflow: full store, repeat tag is fine, new tag flags
    do_reset();
    for (int k = 0; k < ENT; k++) issue(3'd0, 3, 200 + k, 0, "R11");
    issue(3'd0, 3, 205, 2, "R11");
    chk(overflow === 1'b0, "R11", "repeat fill on full store", overflow, 0);
    issue(3'd0, 3, 300, 0, "R11");
    issue(3'd2, 0, 300, 0, "R11");
    issue(3'd2, 0, 215, 0, "R11");
    issue(3'd1, 3, 200, 0, "R11");
    chk(overflow === 1'b1, "R11", "flag sticky", overflow, 1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule